// File: doc/BRIEF.md
# Maintenance Request to Memory-Mapped Bus Bridge

This block sits between a RapidIO packet parser and an internal register space. It takes one parsed MAINTENANCE request record at a time and turns a legal read or write into a single 32-bit transfer on a simple memory-mapped master port. It then returns a response record (format type 8) to the transport side. The request record carries the transaction code, access size, word pointer, 21-bit configuration offset, payload word, source ID and transaction ID.

A read waits for returned bus data and sends it back in a DONE response. A write returns a DONE response with no payload once the bus has taken the write. If the size is illegal or the transaction code is unknown, the block sends an ERROR response and touches the bus not at all. A port-write request is consumed silently, because other logic handles those. Only one request is in flight at a time.

Top module: `mnt_bus_bridge`

## Requirements
- R1: A read (code 0) or write (code 1) whose size field is not 4'b1000 causes no bus strobe and yields a response with status ERROR (4'b0111) and payload 0. The response code is 2 for a read request and 3 for a write request.
- R2: The bus address of every transfer equals {8'h00, offset[20:0], ~wdptr, 2'b00}.
- R3: For a legal write, bus_writedata equals the request payload while bus_write is high.
- R4: A legal read raises bus_read. After the strobe is accepted, the block waits for bus_readdatavalid and then presents a response with format 4'h8, code 2, status DONE (4'b0000) and payload equal to the bus read data.
- R5: A legal write raises bus_write. Once the strobe is accepted, the block presents a response with format 4'h8, code 3, status DONE and payload 0.
- R6: Every response carries the request transaction ID unchanged, and uses the request source ID as its destination ID.
- R7: A port-write request (code 4) produces no bus strobe and no response, and req_ready is high again in the cycle after acceptance.
- R8: Any transaction code other than 0, 1 or 4 produces no bus strobe and an ERROR response with code 3 and payload 0.
- R9: While bus_waitrequest is high, an active strobe, the address and the write data all stay unchanged. The strobe drops in the cycle after bus_waitrequest is seen low.
- R10: req_ready is low from the cycle after an accepted request until the response handshake completes, and it is high again in the following cycle.
- R11: While rsp_valid is high and rsp_ready is low, every response field stays unchanged.
- R12: After reset, req_ready is high, and bus_read, bus_write and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request record valid |
| req_ready | output | 1 | Bridge can take a request |
| req_ttype | input | 4 | Transaction code: 0 read, 1 write, 4 port-write |
| req_size | input | 4 | Access size field, legal value 4'b1000 |
| req_wdptr | input | 1 | Word pointer |
| req_offset | input | 21 | Configuration offset |
| req_payload | input | 32 | Write payload word |
| req_srcid | input | SRC_W | Requester source ID |
| req_tid | input | TID_W | Transaction ID |
| bus_address | output | 32 | Byte address |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_writedata | output | 32 | Write data |
| bus_waitrequest | input | 1 | Slave stall |
| bus_readdata | input | 32 | Read data |
| bus_readdatavalid | input | 1 | Read data valid, at least one cycle after the read is accepted |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Transport takes response |
| rsp_ftype | output | 4 | Response format type, always 8 |
| rsp_ttype | output | 4 | 2 read response, 3 write response |
| rsp_status | output | 4 | 0 DONE, 7 ERROR |
| rsp_destid | output | SRC_W | Destination ID |
| rsp_tid | output | TID_W | Transaction ID |
| rsp_payload | output | 32 | Read data or zero |

## Verification
The bench targets sizes one bit away from 4'b1000. A bridge that checked the size loosely would put a strobe on the bus instead of sending ERROR. It flips the word pointer on both polarities, so a missing inversion shows up as a wrong address bit 2. Long waitrequest stalls and response backpressure would expose a strobe or response field that changes early, or a strobe held one cycle too long. Port-write and unknown codes check that the first causes no response at all and the second returns ERROR with the write response code.

// File: rtl/mnt_bus_bridge.sv
module mnt_bus_bridge #(
  parameter int SRC_W = 16,
  parameter int TID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_ttype,
  input  logic [3:0]       req_size,
  input  logic             req_wdptr,
  input  logic [20:0]      req_offset,
  input  logic [31:0]      req_payload,
  input  logic [SRC_W-1:0] req_srcid,
  input  logic [TID_W-1:0] req_tid,
  output logic [31:0]      bus_address,
  output logic             bus_read,
  output logic             bus_write,
  output logic [31:0]      bus_writedata,
  input  logic             bus_waitrequest,
  input  logic [31:0]      bus_readdata,
  input  logic             bus_readdatavalid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [3:0]       rsp_ftype,
  output logic [3:0]       rsp_ttype,
  output logic [3:0]       rsp_status,
  output logic [SRC_W-1:0] rsp_destid,
  output logic [TID_W-1:0] rsp_tid,
  output logic [31:0]      rsp_payload
);
  localparam logic [3:0] T_READ  = 4'd0;
  localparam logic [3:0] T_WRITE = 4'd1;
  localparam logic [3:0] T_RRSP  = 4'd2;
  localparam logic [3:0] T_WRSP  = 4'd3;
  localparam logic [3:0] T_PW    = 4'd4;
  localparam logic [3:0] SZ_WORD = 4'b1000;
  localparam logic [3:0] ST_DONE = 4'b0000;
  localparam logic [3:0] ST_ERR  = 4'b0111;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WR, S_RSP} state_t;
  state_t state;

  logic [20:0]      r_off;
  logic             r_wdptr;
  logic [31:0]      r_data;
  logic [3:0]       r_rtt;
  logic [3:0]       r_st;
  logic [SRC_W-1:0] r_src;
  logic [TID_W-1:0] r_tid;

  wire take    = req_valid && req_ready;
  wire size_ok = (req_size == SZ_WORD);

  assign req_ready     = (state == S_IDLE);
  assign bus_read      = (state == S_RD);
  assign bus_write     = (state == S_WR);
  assign bus_address   = {8'h00, r_off, ~r_wdptr, 2'b00};
  assign bus_writedata = r_data;
  assign rsp_valid     = (state == S_RSP);
  assign rsp_ftype     = 4'h8;
  assign rsp_ttype     = r_rtt;
  assign rsp_status    = r_st;
  assign rsp_destid    = r_src;
  assign rsp_tid       = r_tid;
  assign rsp_payload   = r_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      r_off   <= '0;
      r_wdptr <= 1'b0;
      r_data  <= '0;
      r_rtt   <= '0;
      r_st    <= '0;
      r_src   <= '0;
      r_tid   <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          r_off   <= req_offset;
          r_wdptr <= req_wdptr;
          r_src   <= req_srcid;
          r_tid   <= req_tid;
          r_data  <= '0;
          r_st    <= ST_DONE;
          case (req_ttype)
            T_READ: begin
              r_rtt <= T_RRSP;
              if (size_ok) state <= S_RD;
              else begin r_st <= ST_ERR; state <= S_RSP; end
            end
            T_WRITE: begin
              r_rtt <= T_WRSP;
              if (size_ok) begin r_data <= req_payload; state <= S_WR; end
              else begin r_st <= ST_ERR; state <= S_RSP; end
            end
            T_PW: state <= S_IDLE;
            default: begin
              r_rtt <= T_WRSP;
              r_st  <= ST_ERR;
              state <= S_RSP;
            end
          endcase
        end
        S_RD:  if (!bus_waitrequest) state <= S_RDW;
        S_RDW: if (bus_readdatavalid) begin
          r_data <= bus_readdata;
          state  <= S_RSP;
        end
        S_WR: if (!bus_waitrequest) begin
          r_data <= '0;
          state  <= S_RSP;
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module mnt_bus_bridge_chk #(
  parameter int SRC_W = 16,
  parameter int TID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [31:0]      bus_address,
  input logic             bus_read,
  input logic             bus_write,
  input logic [31:0]      bus_writedata,
  input logic             bus_waitrequest,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [3:0]       rsp_ttype,
  input logic [3:0]       rsp_status,
  input logic [SRC_W-1:0] rsp_destid,
  input logic [TID_W-1:0] rsp_tid,
  input logic [31:0]      rsp_payload
);
  a_r2_addr_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write) |-> (bus_address[31:24] == 8'h00 && bus_address[1:0] == 2'b00));
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && bus_waitrequest) |=> (bus_read && $stable(bus_address)));
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_waitrequest) |=> (bus_write && $stable(bus_address) && $stable(bus_writedata)));
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && !bus_waitrequest) |=> !(bus_read || bus_write));
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write || rsp_valid) |-> !req_ready);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_read, bus_write, rsp_valid}));
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ttype) && $stable(rsp_status)
      && $stable(rsp_destid) && $stable(rsp_tid) && $stable(rsp_payload)));
  a_r1_err_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 4'b0000) |-> (rsp_payload == 32'd0));
endmodule

bind mnt_bus_bridge mnt_bus_bridge_chk #(.SRC_W(SRC_W), .TID_W(TID_W)) u_chk (.*);

// File: tb/tb_mnt_bus_bridge.sv
module tb_mnt_bus_bridge;
  localparam int SRC_W = 16;
  localparam int TID_W = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [3:0] req_ttype = 0, req_size = 0;
  logic req_wdptr = 0;
  logic [20:0] req_offset = 0;
  logic [31:0] req_payload = 0;
  logic [SRC_W-1:0] req_srcid = 0;
  logic [TID_W-1:0] req_tid = 0;
  logic [31:0] bus_address, bus_writedata;
  logic bus_read, bus_write;
  logic bus_waitrequest = 1;
  logic [31:0] bus_readdata = 0;
  logic bus_readdatavalid = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [3:0] rsp_ftype, rsp_ttype, rsp_status;
  logic [SRC_W-1:0] rsp_destid;
  logic [TID_W-1:0] rsp_tid;
  logic [31:0] rsp_payload;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mnt_bus_bridge #(.SRC_W(SRC_W), .TID_W(TID_W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [20:0] off, input logic wp);
    return {8'h00, off, ~wp, 2'b00};
  endfunction

  // 0 read, 1 write, 2 error, 3 silent
  function automatic int exp_kind(input logic [3:0] tt, input logic [3:0] sz);
    if (tt == 4'd4) return 3;
    if (tt == 4'd0) return (sz == 4'b1000) ? 0 : 2;
    if (tt == 4'd1) return (sz == 4'b1000) ? 1 : 2;
    return 2;
  endfunction

  task automatic run(input logic [3:0] tt, input logic [3:0] sz, input logic wp,
                     input logic [20:0] off, input logic [31:0] pl, input logic [SRC_W-1:0] src,
                     input logic [TID_W-1:0] tid, input int wcyc, input int lat, input int bp);
    int k;
    logic [31:0] rd;
    logic [3:0] ett;
    k = exp_kind(tt, sz);
    rd = $urandom;
    @(negedge clk);
    req_ttype = tt; req_size = sz; req_wdptr = wp; req_offset = off;
    req_payload = pl; req_srcid = src; req_tid = tid; req_valid = 1;
    bus_waitrequest = 1;
    chk(req_ready == 1, "R10 ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    if (k == 3) begin
      for (int i = 0; i < 3; i++) begin
        chk(!bus_read && !bus_write && !rsp_valid, "R7 port-write silent",
            {bus_read, bus_write, rsp_valid}, 0);
        chk(req_ready == 1, "R7 ready after port-write", req_ready, 1);
        @(negedge clk);
      end
      return;
    end
    chk(req_ready == 0, "R10 busy after accept", req_ready, 0);
    if (k == 2) begin
      chk(!bus_read && !bus_write, (tt > 1 && tt != 4) ? "R8 no strobe" : "R1 no strobe",
          {bus_read, bus_write}, 0);
    end else begin
      chk(bus_read == (k == 0) && bus_write == (k == 1), k == 0 ? "R4 read strobe" : "R5 write strobe",
          {bus_read, bus_write}, {k == 0, k == 1});
      chk(bus_address == exp_addr(off, wp), "R2 address", bus_address, exp_addr(off, wp));
      if (k == 1) chk(bus_writedata == pl, "R3 writedata", bus_writedata, pl);
      for (int i = 0; i < wcyc; i++) begin
        @(negedge clk);
        chk((bus_read || bus_write) && bus_address == exp_addr(off, wp) && (k == 0 || bus_writedata == pl),
            "R9 hold under wait", bus_address, exp_addr(off, wp));
      end
      bus_waitrequest = 0;
      @(negedge clk);
      bus_waitrequest = 1;
      chk(!bus_read && !bus_write, "R9 strobe drops", {bus_read, bus_write}, 0);
      if (k == 0) begin
        for (int i = 0; i < lat; i++) begin
          chk(!rsp_valid, "R4 waits for data", rsp_valid, 0);
          @(negedge clk);
        end
        bus_readdata = rd; bus_readdatavalid = 1;
        @(negedge clk);
        bus_readdatavalid = 0; bus_readdata = $urandom;
      end
    end
    ett = (k == 0 || (tt == 0)) ? 4'd2 : 4'd3;
    for (int i = 0; i < bp; i++) begin
      chk(rsp_valid == 1, "R11 valid under backpressure", rsp_valid, 1);
      @(negedge clk);
    end
    chk(rsp_valid == 1, "R10 rsp valid", rsp_valid, 1);
    chk(rsp_ftype == 4'h8, "R4 ftype", rsp_ftype, 8);
    chk(rsp_ttype == ett, k == 2 ? ((tt > 1) ? "R8 rsp code" : "R1 rsp code") : "R5 rsp code", rsp_ttype, ett);
    chk(rsp_status == (k == 2 ? 4'b0111 : 4'b0000), k == 2 ? "R1 status" : "R4 status",
        rsp_status, k == 2 ? 4'b0111 : 4'b0000);
    chk(rsp_payload == (k == 0 ? rd : 32'd0), k == 0 ? "R4 payload" : "R5 payload",
        rsp_payload, k == 0 ? rd : 32'd0);
    chk(rsp_destid == src && rsp_tid == tid, "R6 ids", {rsp_destid, rsp_tid}, {src, tid});
    chk(req_ready == 0, "R10 busy during response", req_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R10 released", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && !bus_read && !bus_write && !rsp_valid, "R12 reset state",
        {req_ready, bus_read, bus_write, rsp_valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && !rsp_valid, "R12 after reset", {req_ready, rsp_valid}, 2'b10);
    run(4'd0, 4'b1000, 1'b0, 21'h1FFFFF, 32'h0, 16'hABCD, 8'h11, 0, 0, 0);
    run(4'd0, 4'b1000, 1'b1, 21'h000001, 32'h0, 16'h0001, 8'hFF, 5, 3, 4);
    run(4'd1, 4'b1000, 1'b0, 21'h0A5A5A, 32'hDEADBEEF, 16'h1234, 8'h22, 4, 0, 2);
    run(4'd1, 4'b1000, 1'b1, 21'h155555, 32'hCAFEF00D, 16'hFFFF, 8'h00, 0, 0, 0);
    run(4'd0, 4'b1001, 1'b0, 21'h3, 32'h0, 16'h7, 8'h33, 0, 0, 1);
    run(4'd1, 4'b0000, 1'b1, 21'h3, 32'h12345678, 16'h8, 8'h44, 0, 0, 0);
    run(4'd1, 4'b1100, 1'b0, 21'h9, 32'h1, 16'h9, 8'h45, 0, 0, 3);
    run(4'd4, 4'b1000, 1'b0, 21'h7, 32'h5, 16'h2, 8'h55, 0, 0, 0);
    run(4'd9, 4'b1000, 1'b0, 21'h7, 32'h5, 16'h3, 8'h66, 0, 0, 2);
    run(4'd2, 4'b1000, 1'b1, 21'h7, 32'h5, 16'h4, 8'h77, 0, 0, 0);
    for (int n = 0; n < 300; n++) begin
      logic [3:0] tt, sz;
      int r;
      r = $urandom_range(0, 9);
      tt = (r < 4) ? 4'd0 : (r < 8) ? 4'd1 : (r == 8) ? 4'd4 : 4'($urandom_range(0, 15));
      sz = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'b1000;
      run(tt, sz, 1'($urandom), 21'($urandom), $urandom, 16'($urandom), 8'($urandom),
          $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 3));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule